// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is a general-purpose timer built around a counter of up to 16 bits. One of four clock-enable strobes is chosen as the count source and then divided by 1, 2, 4 or 8. The resulting tick drives a small state machine that can hold, count up to a programmable limit, run freely up to the largest value of a selectable counter length, or count up to the limit and back down to zero. Everything runs in a single clock domain.

Software can write the count and the limit, pulse a clear, and read or clear an overflow flag. The overflow flag sets when the count wraps back to zero. It raises an interrupt request only while the overflow interrupt enable is high. A one-clock equality strobe marks each tick that moves the count onto the limit value.

The direction state machine has two states. RISE means counting upward and FALL means counting downward. The transitions are:
- RISE to FALL: a tick in up/down mode while the count is at or above a non-zero limit.
- FALL to RISE: a tick in up/down mode while the count is at 1 or 0.
- Any state to RISE: a clear, a zero limit write outside continuous mode, or a tick in up or continuous mode.
- Hold: stop mode keeps the current state.

Top module: `mm_timer`

## Requirements
- R1: After reset, the count, the equality strobe, the overflow flag and the interrupt request are all 0, and the limit is 0.
- R2: Mode code 00 (stop) keeps the count unchanged whether or not ticks arrive.
- R3: Mode code 01 (up) counts 0,1,…,limit on successive ticks. The tick taken at a count at or above the limit loads 0 and sets the overflow flag.
- R4: Mode code 10 (continuous) counts up to the length maximum. The tick taken at a count at or above that maximum loads 0 and sets the overflow flag.
- R5: Mode code 11 (up/down) counts up to the limit, reverses there, and counts down. The step from 1 to 0 sets the overflow flag and turns the direction up again. With a zero limit the count stays at 0.
- R6: Length code 00/01/10/11 sets the continuous-mode maximum to 0xFF/0x3FF/0xFFF/0xFFFF.
- R7: The tick is produced on every 2^d-th strobe of source src_tick[src_sel], where d is the 2-bit divider code. Strobes on unselected sources are ignored.
- R8: A clear pulse sets the count to 0, restarts the divider, and turns the direction up. It has priority over every other update.
- R9: A count write loads the written value on the next clock and has priority over ticks. Writing 0 resets the count.
- R10: Writing 0 to the limit resets the count to 0 (direction up) in stop, up and up/down modes. In continuous mode it leaves the count unchanged.
- R11: In up and up/down modes, the equality strobe is high for the single clock in which the count first shows the limit value after a tick moved it there. It stays low during a limit write.
- R12: The interrupt request equals flag AND enable. A flag write loads the written bit. A wrap in the same cycle wins over a write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 4 | Clock-enable strobes of the four count sources |
| src_sel | input | 2 | Source select |
| div_sel | input | 2 | Divider code: divide by 1, 2, 4, 8 |
| mode | input | 2 | 00 stop, 01 up, 10 continuous, 11 up/down |
| len_sel | input | 2 | Counter length: 8, 10, 12, 16 bits |
| clr | input | 1 | One-clock clear pulse |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| lim_wr | input | 1 | Limit write strobe |
| lim_wdata | input | 16 | Limit write value |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Overflow flag write value |
| ovf_ie | input | 1 | Overflow interrupt enable |
| count | output | 16 | Live count value |
| eq_lim | output | 1 | Equality-to-limit strobe |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a software write of 0 to the overflow flag and a wrap that sets the flag. The second pair is a clear and a tick that would otherwise step the count. The bench provokes the first pair by preloading the count with the limit and issuing the flag write on the very cycle whose tick wraps. It expects the flag to stay set. It provokes the second pair by pulsing the clear while ticks arrive in the middle of a down-count and of a divide-by-8 window. It expects zero, an upward direction and a restarted divider. A behavioural model in the bench judges both cases every clock.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MD_HALT = 2'b00,
        MD_UP   = 2'b01,
        MD_CONT = 2'b10,
        MD_UPDN = 2'b11
    } mmt_mode_e;

    typedef enum logic {
        ST_RISE = 1'b0,
        ST_FALL = 1'b1
    } mmt_dir_e;

    // maximum count for a length code: 8, 10, 12 or 16 bits
    function automatic logic [15:0] len_max(input logic [1:0] code);
        logic [15:0] m;
        unique case (code)
            2'b00: m = 16'h00FF;
            2'b01: m = 16'h03FF;
            2'b10: m = 16'h0FFF;
            default: m = 16'hFFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             clr,
    output logic             tick
);
    localparam int PC_W = (2 ** DIV_W) - 1;

    logic [NSRC-1:0] hit_vec;
    logic            sel_strobe;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] div_last;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            assign hit_vec[gi] = src_tick[gi] && (src_sel == SEL_W'(gi));
        end
    endgenerate

    assign sel_strobe = |hit_vec;
    assign div_last   = PC_W'((1 << div_sel) - 1);
    assign tick       = !clr && sel_strobe && (pc_q >= div_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (clr) begin
            pc_q <= '0;
        end else if (sel_strobe) begin
            if (pc_q >= div_last) pc_q <= '0;
            else                  pc_q <= pc_q + PC_W'(1);
        end
    end

    AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (src_tick[src_sel] && !clr));  // R7

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [1:0]       len_sel,
    input  logic             clr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] lim_wdata,
    output logic [CNT_W-1:0] count,
    output logic             eq_lim,
    output logic             wrap
);
    mmt_dir_e         st_q, st_n;
    mmt_mode_e        md;
    logic [CNT_W-1:0] cnt_q, cnt_n, lim_q, maxv;
    logic             zero_lim_rst, on_path, hit;

    assign md           = mmt_mode_e'(mode);
    assign maxv         = CNT_W'(len_max(len_sel));
    assign zero_lim_rst = lim_wr && (lim_wdata == '0) && (md != MD_CONT);

    always_comb begin
        cnt_n   = cnt_q;
        st_n    = st_q;
        wrap    = 1'b0;
        on_path = 1'b0;
        if (clr) begin
            cnt_n = '0;
            st_n  = ST_RISE;
        end else if (cnt_wr) begin
            cnt_n = cnt_wdata;
        end else if (zero_lim_rst) begin
            cnt_n = '0;
            st_n  = ST_RISE;
        end else if (tick) begin
            on_path = 1'b1;
            unique case (md)
                MD_HALT: begin
                    cnt_n = cnt_q;
                end
                MD_UP: begin
                    st_n = ST_RISE;
                    if (cnt_q >= lim_q) begin
                        cnt_n = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                MD_CONT: begin
                    st_n = ST_RISE;
                    if (cnt_q >= maxv) begin
                        cnt_n = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                MD_UPDN: begin
                    unique case (st_q)
                        ST_RISE: begin
                            if (cnt_q >= lim_q) begin
                                if (cnt_q != '0) begin
                                    cnt_n = cnt_q - CNT_W'(1);
                                    st_n  = ST_FALL;
                                end
                            end else begin
                                cnt_n = cnt_q + CNT_W'(1);
                            end
                        end
                        ST_FALL: begin
                            if (cnt_q <= CNT_W'(1)) begin
                                cnt_n = '0;
                                st_n  = ST_RISE;
                                wrap  = (cnt_q == CNT_W'(1));
                            end else begin
                                cnt_n = cnt_q - CNT_W'(1);
                            end
                        end
                        default: st_n = ST_RISE;
                    endcase
                end
                default: cnt_n = cnt_q;
            endcase
        end
    end

    assign hit = on_path && !lim_wr && ((md == MD_UP) || (md == MD_UPDN)) &&
                 (cnt_n == lim_q) && (cnt_n != cnt_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RISE;
        else        st_q <= st_n;
    end

    // output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            eq_lim <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            eq_lim <= hit;
            if (lim_wr) lim_q <= lim_wdata;
        end
    end

    assign count = cnt_q;

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_HALT && !clr && !cnt_wr && !zero_lim_rst) |=> (cnt_q == $past(cnt_q)));  // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && st_q == ST_RISE));  // R8
    AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        eq_lim |-> (cnt_q == lim_q));  // R11
    AST_EQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eq_lim |=> !eq_lim);  // R11
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !clr) |=> (cnt_q == $past(cnt_wdata)));  // R9

endmodule

// File: rtl/mmt_flags.sv
module mmt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic flag_wr,
    input  logic flag_wdata,
    input  logic ovf_ie,
    output logic ovf_flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (flag_wr) ovf_flag <= flag_wdata;
    end

    assign irq = ovf_flag && ovf_ie;

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag) && !$past(flag_wr)) |-> $past(wrap));  // R12
    AST_WRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);  // R12

endmodule

// File: rtl/mm_timer.sv
module mm_timer #(
    parameter int CNT_W = 16,
    parameter int NSRC  = 4,
    parameter int DIV_W = 2,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [1:0]       mode,
    input  logic [1:0]       len_sel,
    input  logic             clr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] lim_wdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             ovf_ie,
    output logic [CNT_W-1:0] count,
    output logic             eq_lim,
    output logic             ovf_flag,
    output logic             irq
);
    logic tick, wrap;

    mmt_prescaler #(.NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
        .div_sel(div_sel), .clr(clr), .tick(tick)
    );

    mmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .len_sel(len_sel),
        .clr(clr), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .lim_wr(lim_wr),
        .lim_wdata(lim_wdata), .count(count), .eq_lim(eq_lim), .wrap(wrap)
    );

    mmt_flags u_flg (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .ovf_ie(ovf_ie), .ovf_flag(ovf_flag), .irq(irq)
    );

    AST_WRAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> tick);  // R3

endmodule

// File: tb/tb_mm_timer.sv
`timescale 1ns/1ps
module tb_mm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic [1:0]  src_sel = '0, div_sel = '0, mode = '0, len_sel = '0;
    logic        clr = 0, cnt_wr = 0, lim_wr = 0, flag_wr = 0, flag_wdata = 0, ovf_ie = 0;
    logic [15:0] cnt_wdata = '0, lim_wdata = '0;
    logic [15:0] count;
    logic        eq_lim, ovf_flag, irq;

    int n_cmp = 0, n_bad = 0;
    int m_cnt = 0, m_lim = 0, m_dir = 0, m_pc = 0, m_flag = 0, m_eq = 0;
    int src_pat = 0;  // 0 all strobes, 1 random, 2 none
    string tag = "R1";

    always #5 clk = ~clk;

    mm_timer dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_sel(src_sel),
        .div_sel(div_sel), .mode(mode), .len_sel(len_sel), .clr(clr),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ovf_ie(ovf_ie),
        .count(count), .eq_lim(eq_lim), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(string req, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int tk = 0, nc = m_cnt, nd = m_dir, wr = 0, onp = 0, mx, dl;
        dl = (1 << div_sel) - 1;
        if (clr) m_pc = 0;
        else if (src_tick[src_sel]) begin
            if (m_pc >= dl) begin m_pc = 0; tk = 1; end
            else m_pc++;
        end
        case (len_sel)
            2'd0: mx = 'hFF; 2'd1: mx = 'h3FF; 2'd2: mx = 'hFFF; default: mx = 'hFFFF;
        endcase
        if (clr) begin nc = 0; nd = 0; end
        else if (cnt_wr) nc = int'(cnt_wdata);
        else if (lim_wr && lim_wdata == 0 && mode != 2) begin nc = 0; nd = 0; end
        else if (tk == 1) begin
            onp = 1;
            if (mode == 1) begin
                nd = 0;
                if (m_cnt >= m_lim) begin nc = 0; wr = 1; end else nc = m_cnt + 1;
            end else if (mode == 2) begin
                nd = 0;
                if (m_cnt >= mx) begin nc = 0; wr = 1; end else nc = m_cnt + 1;
            end else if (mode == 3) begin
                if (m_dir == 0) begin
                    if (m_cnt >= m_lim) begin
                        if (m_cnt != 0) begin nc = m_cnt - 1; nd = 1; end
                    end else nc = m_cnt + 1;
                end else begin
                    if (m_cnt <= 1) begin wr = (m_cnt == 1); nc = 0; nd = 0; end
                    else nc = m_cnt - 1;
                end
            end
        end
        m_eq = (onp == 1 && !lim_wr && (mode == 1 || mode == 3) && nc == m_lim && nc != m_cnt) ? 1 : 0;
        if (wr == 1) m_flag = 1;
        else if (flag_wr) m_flag = int'(flag_wdata);
        if (lim_wr) m_lim = int'(lim_wdata);
        m_cnt = nc;
        m_dir = nd;
    endtask

    task automatic cyc();
        if (src_pat == 0) src_tick = 4'hF;
        else if (src_pat == 1) src_tick = 4'($urandom);
        else src_tick = 4'h0;
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        check(tag, int'(count), m_cnt, "count");
        check(tag, int'(eq_lim), m_eq, "eq_lim");
        check(tag, int'(ovf_flag), m_flag, "ovf_flag");
        check(tag, int'(irq), (m_flag == 1 && ovf_ie) ? 1 : 0, "irq");
        clr = 0; cnt_wr = 0; lim_wr = 0; flag_wr = 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_cnt(int v);
        cnt_wr = 1; cnt_wdata = 16'(v); cyc();
    endtask

    task automatic wr_lim(int v);
        lim_wr = 1; lim_wdata = 16'(v); cyc();
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1", int'(count), 0, "count");
        check("R1", int'(eq_lim), 0, "eq_lim");
        check("R1", int'(ovf_flag), 0, "ovf_flag");
        check("R1", int'(irq), 0, "irq");
        run(3);

        // R9 count write, R2 stop holds under ticks
        tag = "R9"; wr_cnt(5);
        check("R9", int'(count), 5, "written count");
        tag = "R2"; run(10);
        check("R2", int'(count), 5, "held count");

        // R3 up mode with limit 4, R11 equality strobe
        tag = "R3"; wr_lim(4); mode = 2'b01; wr_cnt(0); run(14);
        tag = "R11"; wr_cnt(2); cyc();
        check("R11", int'(count), 3, "count before limit");
        cyc();
        check("R11", int'(eq_lim), 1, "strobe at limit");
        cyc();
        check("R11", int'(eq_lim), 0, "strobe one clock");

        // R7 source select and divider with random strobes
        tag = "R7"; src_pat = 1;
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            for (int s = 0; s < 4; s++) begin src_sel = 2'(s); run(25); end
        end
        src_pat = 2; src_sel = 2'd1; run(6);
        src_pat = 0; div_sel = 0; src_sel = 0;

        // R4/R6 continuous wrap at each length
        mode = 2'b10;
        for (int l = 0; l < 4; l++) begin
            tag = "R6"; len_sel = 2'(l);
            wr_cnt((l == 3) ? 'hFFFC : ((1 << (8 + 2 * l)) - 4));
            tag = "R4"; run(8);
        end
        check("R4", int'(ovf_flag), 1, "flag after wrap");
        len_sel = 2'd0; wr_cnt('h500); run(3);  // above 8-bit max

        // R12 irq gating and flag write
        tag = "R12"; ovf_ie = 1; cyc();
        check("R12", int'(irq), 1, "irq with enable");
        flag_wr = 1; flag_wdata = 0; cyc();
        ovf_ie = 0;
        // coincidence: wrap and flag clear in the same cycle
        mode = 2'b01; wr_lim(3); wr_cnt(3);
        flag_wr = 1; flag_wdata = 0; cyc();
        check("R12", int'(ovf_flag), 1, "wrap wins over clear");
        mode = 2'b00; flag_wr = 1; flag_wdata = 0; cyc();
        check("R12", int'(ovf_flag), 0, "cleared");

        // R5 up/down
        tag = "R5"; mode = 2'b11; wr_cnt(0); run(20);
        div_sel = 2'd1; run(16); div_sel = 0;

        // R8 clear while descending and mid-prescale
        tag = "R8"; wr_lim(6); wr_cnt(0); run(9);
        clr = 1; cyc();
        check("R8", int'(count), 0, "clear");
        run(8);
        div_sel = 2'd3; run(5); clr = 1; cyc(); run(20); div_sel = 0;

        // R10 zero limit write
        tag = "R10"; mode = 2'b01; wr_lim(9); wr_cnt(7); run(1);
        wr_lim(0);
        check("R10", int'(count), 0, "zero limit reset");
        run(4);
        mode = 2'b10; src_pat = 2; wr_cnt('h42); wr_lim(0);
        check("R10", int'(count), 'h42, "continuous ignores zero limit");
        src_pat = 0; run(5);

        // R9 writing zero resets count
        tag = "R9"; wr_cnt(0);
        check("R9", int'(count), 0, "zero write");
        run(3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule